// File: doc/BRIEF.md
# Funnel Shifter with Shift-Amount Register

This block is the 32-bit shift unit of a small processor datapath. It keeps one 6-bit shift-amount register and produces one 32-bit result per cycle, chosen by an operation code. Three operations take their amount from a 5-bit immediate: left, logical-right and arithmetic-right. Three more take their amount from the register in the same three directions. The last one is a right funnel shift of two concatenated operands by the register amount.

The register can be loaded in three ways. A direct write stores a full value from 0 to 32. A right setup stores a 5-bit amount as given. A left setup stores the complement of a 5-bit amount against 32. A left shift by register moves the operand by 32 minus the stored value, so one setup value serves both directions. Every register-driven shift supports the full range 0 to 32. At 32, a result is zero-filled or sign-filled and never wraps around.

The result is combinational from the current inputs and the register. A register update takes effect at the next rising clock edge.

Top module: `fshift_unit`

## Requirements
- R1: While rst_ni is low, the register is 0 and amt_rdata_o reads 0.
- R2: When amt_we_i is high at a rising edge, the register takes amt_wdata_i, or 32 if amt_wdata_i is above 32. amt_rdata_o always returns the register zero-extended to 32 bits, and its value never exceeds 32.
- R3: When setup_en_i=1 and setup_left_i=1 at an edge, and there is no direct write, the register takes 32 minus setup_amt_i. setup_amt_i is 5 bits, so a requested 32 arrives as 0 and stores 32.
- R4: When setup_en_i=1 and setup_left_i=0 at an edge, and there is no direct write, the register takes setup_amt_i (0 to 31).
- R5: When amt_we_i and setup_en_i are both high at the same edge, the direct write decides the new register value. With neither high, the register holds its value.
- R6: With op_i=3 (left by register), result_o is src_a_i shifted left by 32 minus the register value. A register value of 0 gives 0.
- R7: With op_i=4 (logical right by register), result_o is src_a_i shifted right by the register value with zero fill. A register value of 32 gives 0.
- R8: With op_i=5 (arithmetic right by register), vacated bits copy src_a_i[31]. A register value of 32 gives 32 copies of src_a_i[31].
- R9: With op_i=6 (funnel right), result_o is the low 32 bits of {src_a_i, src_b_i} shifted right by the register value. A register value of 32 returns src_a_i.
- R10: With op_i=0, 1 or 2, result_o is src_a_i shifted left, logically right or arithmetically right by imm_i (0 to 31), and the register is not used. An amount of 0 returns src_a_i.
- R11: result_o reflects the current inputs and the register value in the same cycle. A shift issued in the same cycle as a register update still uses the old value.
- R12: op_i=7 gives result_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (0 left imm, 1 logical right imm, 2 arithmetic right imm, 3 left reg, 4 logical right reg, 5 arithmetic right reg, 6 funnel right, 7 none) |
| src_a_i | input | 32 | Shifted operand; upper word of the funnel |
| src_b_i | input | 32 | Lower word of the funnel |
| imm_i | input | 5 | Immediate shift amount |
| setup_en_i | input | 1 | Load the register from a setup amount |
| setup_left_i | input | 1 | 1: left setup (store 32 minus amount); 0: right setup |
| setup_amt_i | input | 5 | Setup amount |
| amt_we_i | input | 1 | Direct write enable |
| amt_wdata_i | input | 6 | Direct write value (saturated to 32) |
| amt_rdata_o | output | 32 | Register value, zero-extended |
| result_o | output | 32 | Shift result |

## Verification
result_o is due in the same cycle its inputs are applied, with no register on the path. amt_rdata_o and any register-driven result change only one rising edge after a setup or direct write. The bench drives each stimulus on a falling edge and samples both outputs 1 ns before the next rising edge. It computes the expected values from the register value its model holds before that edge, and it updates the model only after queuing the expected item. Because of this ordering, a shift issued in the same cycle as an update is checked against the old amount, and the next cycle is checked against the new one.

// File: rtl/fshift_pkg.sv
package fshift_pkg;
  parameter int unsigned DATA_W = 32;

  typedef enum logic [2:0] {
    OP_SL_IMM  = 3'd0,
    OP_SRL_IMM = 3'd1,
    OP_SRA_IMM = 3'd2,
    OP_SL_REG  = 3'd3,
    OP_SRL_REG = 3'd4,
    OP_SRA_REG = 3'd5,
    OP_FSR_REG = 3'd6,
    OP_NONE    = 3'd7
  } op_e;
endpackage

// File: rtl/fshift_amt_reg.sv
module fshift_amt_reg #(
  parameter int unsigned DATA_W = fshift_pkg::DATA_W,
  localparam int unsigned SH_W  = $clog2(DATA_W),
  localparam int unsigned AMT_W = SH_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             setup_en_i,
  input  logic             setup_left_i,
  input  logic [SH_W-1:0]  setup_amt_i,
  input  logic             we_i,
  input  logic [AMT_W-1:0] wdata_i,
  output logic [AMT_W-1:0] amt_o
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic [AMT_W-1:0] amt_q, amt_d, setup_val, wr_val;

  // left setup stores the complement so left shifts reuse the same amount
  assign setup_val = setup_left_i ? (FULL - {1'b0, setup_amt_i}) : {1'b0, setup_amt_i};
  assign wr_val    = (wdata_i > FULL) ? FULL : wdata_i;

  always_comb begin
    amt_d = amt_q;
    if (we_i)            amt_d = wr_val;
    else if (setup_en_i) amt_d = setup_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) amt_q <= '0;
    else         amt_q <= amt_d;
  end

  assign amt_o = amt_q;
endmodule

// File: rtl/fshift_ctrl.sv
module fshift_ctrl
  import fshift_pkg::*;
#(
  parameter int unsigned DATA_W = fshift_pkg::DATA_W,
  localparam int unsigned SH_W  = $clog2(DATA_W),
  localparam int unsigned AMT_W = SH_W + 1
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [SH_W-1:0]   imm_i,
  input  logic [AMT_W-1:0]  reg_amt_i,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o,
  output logic [AMT_W-1:0]  amt_o
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic [DATA_W-1:0] sign_fill;
  logic [AMT_W-1:0]  imm_ext;

  assign sign_fill = {DATA_W{src_a_i[DATA_W-1]}};
  assign imm_ext   = {1'b0, imm_i};

  // every operation maps onto one right shift of {hi,lo}; left by n == right by W-n
  always_comb begin
    hi_o  = '0;
    lo_o  = '0;
    amt_o = '0;
    unique case (op_e'(op_i))
      OP_SL_IMM:  begin hi_o = src_a_i;   lo_o = '0;      amt_o = FULL - imm_ext; end
      OP_SRL_IMM: begin hi_o = '0;        lo_o = src_a_i; amt_o = imm_ext;        end
      OP_SRA_IMM: begin hi_o = sign_fill; lo_o = src_a_i; amt_o = imm_ext;        end
      OP_SL_REG:  begin hi_o = src_a_i;   lo_o = '0;      amt_o = reg_amt_i;      end
      OP_SRL_REG: begin hi_o = '0;        lo_o = src_a_i; amt_o = reg_amt_i;      end
      OP_SRA_REG: begin hi_o = sign_fill; lo_o = src_a_i; amt_o = reg_amt_i;      end
      OP_FSR_REG: begin hi_o = src_a_i;   lo_o = src_b_i; amt_o = reg_amt_i;      end
      default:    begin hi_o = '0;        lo_o = '0;      amt_o = '0;             end
    endcase
  end
endmodule

// File: rtl/fshift_barrel.sv
module fshift_barrel #(
  parameter int unsigned DATA_W = fshift_pkg::DATA_W,
  localparam int unsigned SH_W  = $clog2(DATA_W),
  localparam int unsigned AMT_W = SH_W + 1,
  localparam int unsigned CAT_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] res_o
);
  logic [AMT_W-1:0][CAT_W-1:0] stage;

  assign stage[0] = {hi_i, lo_i};

  for (genvar k = 0; k < AMT_W - 1; k++) begin : g_stage
    localparam int unsigned STEP = 2 ** k;
    assign stage[k+1] = amt_i[k] ? (stage[k] >> STEP) : stage[k];
  end

  // top stage moves a whole word; only the low word is kept
  assign res_o = amt_i[AMT_W-1] ? stage[AMT_W-1][CAT_W-1:DATA_W]
                                : stage[AMT_W-1][DATA_W-1:0];
endmodule

// File: rtl/fshift_unit.sv
module fshift_unit #(
  parameter int unsigned DATA_W = fshift_pkg::DATA_W,
  localparam int unsigned SH_W  = $clog2(DATA_W),
  localparam int unsigned AMT_W = SH_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [SH_W-1:0]   imm_i,
  input  logic              setup_en_i,
  input  logic              setup_left_i,
  input  logic [SH_W-1:0]   setup_amt_i,
  input  logic              amt_we_i,
  input  logic [AMT_W-1:0]  amt_wdata_i,
  output logic [DATA_W-1:0] amt_rdata_o,
  output logic [DATA_W-1:0] result_o
);
  logic [AMT_W-1:0]  reg_amt, sh_amt;
  logic [DATA_W-1:0] hi, lo;

  fshift_amt_reg #(.DATA_W(DATA_W)) u_amt_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .setup_en_i   (setup_en_i),
    .setup_left_i (setup_left_i),
    .setup_amt_i  (setup_amt_i),
    .we_i         (amt_we_i),
    .wdata_i      (amt_wdata_i),
    .amt_o        (reg_amt)
  );

  fshift_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .op_i      (op_i),
    .src_a_i   (src_a_i),
    .src_b_i   (src_b_i),
    .imm_i     (imm_i),
    .reg_amt_i (reg_amt),
    .hi_o      (hi),
    .lo_o      (lo),
    .amt_o     (sh_amt)
  );

  fshift_barrel #(.DATA_W(DATA_W)) u_barrel (
    .hi_i  (hi),
    .lo_i  (lo),
    .amt_i (sh_amt),
    .res_o (result_o)
  );

  assign amt_rdata_o = {{(DATA_W-AMT_W){1'b0}}, reg_amt};
endmodule

// File: rtl/fshift_unit_chk.sv
module fshift_unit_chk #(
  parameter int unsigned DATA_W = fshift_pkg::DATA_W,
  localparam int unsigned SH_W  = $clog2(DATA_W),
  localparam int unsigned AMT_W = SH_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] src_a_i,
  input logic              setup_en_i,
  input logic              setup_left_i,
  input logic [SH_W-1:0]   setup_amt_i,
  input logic              amt_we_i,
  input logic [AMT_W-1:0]  amt_wdata_i,
  input logic [DATA_W-1:0] amt_rdata_o,
  input logic [DATA_W-1:0] result_o
);
  localparam logic [DATA_W-1:0] FULL = DATA_W'(DATA_W);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_zero: assert (amt_rdata_o == '0);
  end

  a_r2_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amt_rdata_o <= FULL);

  a_r2_direct_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amt_we_i |=> amt_rdata_o == ((DATA_W'($past(amt_wdata_i)) > FULL) ? FULL
                                                                      : DATA_W'($past(amt_wdata_i))));

  a_r3_left_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_en_i && setup_left_i && !amt_we_i) |=>
      amt_rdata_o == FULL - DATA_W'($past(setup_amt_i)));

  a_r4_right_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_en_i && !setup_left_i && !amt_we_i) |=>
      amt_rdata_o == DATA_W'($past(setup_amt_i)));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!setup_en_i && !amt_we_i) |=> $stable(amt_rdata_o));

  a_r6_left_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd3 && amt_rdata_o == '0) |-> result_o == '0);

  a_r7_srl_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4 && amt_rdata_o == FULL) |-> result_o == '0);

  a_r8_sra_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd5 && amt_rdata_o == FULL) |-> result_o == {DATA_W{src_a_i[DATA_W-1]}});

  a_r9_funnel_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd6 && amt_rdata_o == FULL) |-> result_o == src_a_i);

  a_r12_no_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd7) |-> result_o == '0);
endmodule

bind fshift_unit fshift_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .op_i         (op_i),
  .src_a_i      (src_a_i),
  .setup_en_i   (setup_en_i),
  .setup_left_i (setup_left_i),
  .setup_amt_i  (setup_amt_i),
  .amt_we_i     (amt_we_i),
  .amt_wdata_i  (amt_wdata_i),
  .amt_rdata_o  (amt_rdata_o),
  .result_o     (result_o)
);

// File: tb/fshift_unit_bench.sv
`timescale 1ns/1ps
module fshift_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = 3'd7;
  logic [31:0] src_a_i = '0, src_b_i = '0;
  logic [4:0]  imm_i = '0;
  logic        setup_en_i = 1'b0, setup_left_i = 1'b0;
  logic [4:0]  setup_amt_i = '0;
  logic        amt_we_i = 1'b0;
  logic [5:0]  amt_wdata_i = '0;
  logic [31:0] amt_rdata_o, result_o;

  int checks = 0;
  int errors = 0;
  logic [5:0] m_sar = '0;

  typedef struct {
    logic [31:0] res;
    logic [31:0] rd;
    string       tag;
  } item_t;
  item_t sb[$];

  always #5 clk_i = ~clk_i;

  fshift_unit u_fshift_unit (.*);

  function automatic logic [31:0] exp_res(input logic [2:0] op, input logic [31:0] a, b,
                                          input logic [4:0] imm, input logic [5:0] sar);
    logic [63:0] cat;
    case (op)
      3'd0: return a << imm;
      3'd1: return a >> imm;
      3'd2: return 32'($signed(a) >>> imm);
      3'd3: return (sar == 6'd0) ? 32'd0 : (a << (6'd32 - sar));
      3'd4: return a >> sar;
      3'd5: return 32'($signed(a) >>> sar);
      3'd6: begin cat = {a, b} >> sar; return cat[31:0]; end
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] got, exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [31:0] a, b, input logic [4:0] imm,
                       input logic sen, sleft, input logic [4:0] samt,
                       input logic we, input logic [5:0] wd, input string tag);
    item_t it;
    @(negedge clk_i);
    op_i = op; src_a_i = a; src_b_i = b; imm_i = imm;
    setup_en_i = sen; setup_left_i = sleft; setup_amt_i = samt;
    amt_we_i = we; amt_wdata_i = wd;
    it.res = exp_res(op, a, b, imm, m_sar);
    it.rd  = {26'd0, m_sar};
    it.tag = tag;
    sb.push_back(it);
    if (we)       m_sar = (wd > 6'd32) ? 6'd32 : wd;
    else if (sen) m_sar = sleft ? (6'd32 - {1'b0, samt}) : {1'b0, samt};
  endtask

  task automatic shift(input logic [2:0] op, input logic [31:0] a, b, input logic [4:0] imm,
                       input string tag);
    drive(op, a, b, imm, 1'b0, 1'b0, 5'd0, 1'b0, 6'd0, tag);
  endtask

  // monitor: compare 1 ns before the next rising edge
  initial begin
    forever begin
      @(negedge clk_i);
      #4;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, "result", result_o, it.res);
        check(it.tag, "amt_rdata", amt_rdata_o, it.rd);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] vals[2];
    int amts[6];
    int imms[8];
    int wvals[7];
    vals[0] = 32'ha3c51249; vals[1] = 32'h49a3c512;
    amts  = '{0, 1, 7, 16, 31, 32};
    imms  = '{0, 1, 2, 7, 8, 15, 16, 31};
    wvals = '{0, 1, 8, 17, 31, 32, 45};

    // R1: reset state, left-by-register with register 0 also gives 0
    op_i = 3'd3; src_a_i = 32'hffffffff;
    repeat (2) @(negedge clk_i);
    #4;
    check("R1", "amt_rdata in reset", amt_rdata_o, 32'd0);
    check("R1", "result in reset", result_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R10: immediate forms
    foreach (vals[v]) foreach (imms[i]) begin
      shift(3'd0, vals[v], 32'h0, 5'(imms[i]), "R10");
      shift(3'd1, vals[v], 32'h0, 5'(imms[i]), "R10");
      shift(3'd2, vals[v], 32'h0, 5'(imms[i]), "R10");
    end

    // R4 right setup, R7/R8/R9 by register; R11 old value used in setup cycle
    foreach (amts[i]) begin
      drive(3'd4, vals[0], 32'h0, 5'd3, 1'b1, 1'b0, 5'(amts[i]), 1'b0, 6'd0, "R11");
      foreach (vals[v]) begin
        shift(3'd4, vals[v], 32'h0, 5'd0, "R7");
        shift(3'd5, vals[v], 32'h0, 5'd0, "R8");
        shift(3'd6, vals[v], 32'h215c3a94, 5'd0, "R9");
      end
    end

    // R3 left setup, R6 left by register
    foreach (amts[i]) begin
      drive(3'd3, vals[0], 32'h0, 5'd0, 1'b1, 1'b1, 5'(amts[i]), 1'b0, 6'd0, "R3");
      shift(3'd3, vals[0], 32'h0, 5'd0, "R6");
      shift(3'd3, vals[1], 32'h0, 5'd0, "R6");
    end

    // R2 direct write including 0, 32 and saturation above 32
    foreach (wvals[i]) begin
      drive(3'd6, vals[1], 32'h215c3a94, 5'd0, 1'b0, 1'b0, 5'd0, 1'b1, 6'(wvals[i]), "R2");
      shift(3'd3, vals[0], 32'h0, 5'd0, "R6");
      shift(3'd4, vals[0], 32'h0, 5'd0, "R7");
      shift(3'd5, vals[0], 32'h0, 5'd0, "R8");
      shift(3'd6, vals[0], 32'h215c3a94, 5'd0, "R9");
    end

    // R5 direct write wins over both setup kinds
    drive(3'd7, vals[0], 32'h0, 5'd0, 1'b1, 1'b1, 5'd4, 1'b1, 6'd9, "R5");
    shift(3'd4, vals[0], 32'h0, 5'd0, "R5");
    drive(3'd7, vals[0], 32'h0, 5'd0, 1'b1, 1'b0, 5'd20, 1'b1, 6'd32, "R5");
    shift(3'd5, vals[0], 32'h0, 5'd0, "R5");
    shift(3'd5, vals[1], 32'h0, 5'd0, "R5");

    // R12 unused code
    shift(3'd7, vals[0], vals[1], 5'd5, "R12");
    shift(3'd7, 32'hffffffff, 32'hffffffff, 5'd31, "R12");

    repeat (3) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule